// File: doc/BRIEF.md
# Dual-Rate Clock Divider

This block makes a slow square wave from a fast system clock. A free-running counter counts system clock cycles up to a limit. When the count reaches the limit, the counter returns to zero and raises a pulse that lasts one cycle. On the following edge, that pulse inverts a flop that drives the output. Each half-period of the output therefore lasts the limit plus one cycles.

The limit is taken at run time from one of two constants, selected by a one-bit rate input. The fast constant defaults to one fifth of the slow one, and both are overridable parameters. The output is an ordinary logic signal driven by a flop. It is intended as a slow timing strobe or an indicator drive, not as a clock for other flops. Switching rates is not glitch-free, and the two rates keep no phase relation to each other.

Reset is active low and asynchronous. It clears the output at once. Its release passes through a two-flop synchronizer, so the count starts two edges after the reset input goes high.

Top module: `ratediv_top`

## Requirements
- R1: While `rst_n` is low, `clk_out` is 0, and it falls to 0 as soon as `rst_n` falls, with no clock edge needed.
- R2: With `rate_fast` at 0, after `rst_n` rises the first rising edge of `clk_out` comes on clock edge number SLOW_DIV+4 after the release: 2 edges for reset synchronization, SLOW_DIV+1 edges of counting, and 1 edge for the output flop.
- R3: With `rate_fast` = 0 (slow rate), every half-period of `clk_out` lasts SLOW_DIV+1 clock cycles.
- R4: With `rate_fast` = 1 (fast rate), every half-period of `clk_out` lasts FAST_DIV+1 clock cycles.
- R5: When FAST_DIV is not overridden, it equals SLOW_DIV/5, so a fast half-period is SLOW_DIV/5+1 cycles.
- R6: If the rate changes to a limit below the current count, the counter goes to zero and raises its pulse on the next edge, and `clk_out` toggles on the edge after that. The counter never runs past the larger limit.
- R7: On a change from the fast rate to the slow rate, the counter keeps counting from its current value up to the slow limit, so the half-period in progress is lengthened.
- R8: `clk_out` changes only on the edge that follows a wrap pulse, and it changes exactly once per pulse.
- R9: The wrap pulse never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized |
| rate_fast | input | 1 | 0 selects the slow limit, 1 selects the fast limit |
| clk_out | output | 1 | Divided square wave, driven by a flop |

## Verification
The hardest state to reach from the ports is a counter sitting above the newly selected limit. It occurs only when the rate moves from slow to fast late in a slow half-period. The bench reaches it on purpose: it runs a reference model alongside the design, waits until the model's count is well past the fast limit, and then raises `rate_fast` on a chosen cycle. It then checks that the output holds for one edge and toggles on the next. Random segments of held rate values, of random length, switch in both directions at arbitrary counts and cover the same situation again. A reset asserted between edges while the output is high shows that the clear is asynchronous.

// File: rtl/ratediv_pkg.sv
`timescale 1ns/1ps
package ratediv_pkg;
  localparam int unsigned DEF_SLOW_DIV = 10_000_000;
  localparam int unsigned RATE_RATIO   = 5;
  localparam int unsigned DEF_CNT_W    = 32;

  typedef enum logic {
    RATE_SLOW = 1'b0,
    RATE_FAST = 1'b1
  } rate_e;
endpackage

// File: rtl/ratediv_rst_sync.sv
`timescale 1ns/1ps
// Asserts asynchronously, releases after STAGES rising edges (STAGES >= 2).
module ratediv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ratediv_limit_sel.sv
`timescale 1ns/1ps
// Pure combinational choice of the active division limit.
module ratediv_limit_sel
  import ratediv_pkg::*;
#(
  parameter int unsigned CNT_W    = DEF_CNT_W,
  parameter int unsigned SLOW_DIV = DEF_SLOW_DIV,
  parameter int unsigned FAST_DIV = DEF_SLOW_DIV / RATE_RATIO
) (
  input  logic             rate_fast,
  output logic [CNT_W-1:0] limit
);
  localparam logic [CNT_W-1:0] SLOW_L = CNT_W'(SLOW_DIV);
  localparam logic [CNT_W-1:0] FAST_L = CNT_W'(FAST_DIV);

  rate_e rate;

  always_comb begin
    rate  = rate_e'(rate_fast);
    limit = (rate == RATE_FAST) ? FAST_L : SLOW_L;
  end
endmodule

// File: rtl/ratediv_counter.sv
`timescale 1ns/1ps
// Free-running counter; wraps and pulses when at or beyond the limit.
module ratediv_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_d;
  logic             tick_d;
  logic             at_limit;

  // ">=" rather than "==": a limit lowered below the count wraps at once.
  always_comb begin
    at_limit = (cnt >= limit);
    if (at_limit) begin
      cnt_d  = '0;
      tick_d = 1'b1;
    end else begin
      cnt_d  = cnt + 1'b1;
      tick_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      cnt  <= cnt_d;
      tick <= tick_d;
    end
  end
endmodule

// File: rtl/ratediv_toggle.sv
`timescale 1ns/1ps
// Output flop that inverts when enabled.
module ratediv_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic q
);
  logic q_d;

  always_comb q_d = en ? ~q : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end
endmodule

// File: rtl/ratediv_top.sv
`timescale 1ns/1ps
module ratediv_top
  import ratediv_pkg::*;
#(
  parameter int unsigned CNT_W       = DEF_CNT_W,
  parameter int unsigned SLOW_DIV    = DEF_SLOW_DIV,
  parameter int unsigned FAST_DIV    = SLOW_DIV / RATE_RATIO,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_fast,
  output logic clk_out
);
  logic             rst_sync_n;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt;
  logic             tick;

  ratediv_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ratediv_limit_sel #(
    .CNT_W    (CNT_W),
    .SLOW_DIV (SLOW_DIV),
    .FAST_DIV (FAST_DIV)
  ) u_sel (
    .rate_fast (rate_fast),
    .limit     (limit)
  );

  ratediv_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .limit (limit),
    .cnt   (cnt),
    .tick  (tick)
  );

  ratediv_toggle u_tgl (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (tick),
    .q     (clk_out)
  );
endmodule

// File: rtl/ratediv_checker.sv
`timescale 1ns/1ps
module ratediv_checker #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_sync_n,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] limit,
  input logic             tick,
  input logic             clk_out
);
  // R1: reset input low means cleared state
  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (clk_out == 1'b0 && tick == 1'b0 && cnt == '0)
        else $error("reset did not clear state");
    end
  end

  // R6: a count above the limit wraps on the next edge
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cnt > limit) |=> (cnt == '0 && tick));

  // R3: below the limit the count advances by one
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cnt < limit) |=> (cnt == $past(cnt) + 1'b1 && !tick));

  // R8: output inverts after a pulse
  assert_toggle_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tick |=> (clk_out != $past(clk_out)));

  // R8: output holds without a pulse
  assert_hold_no_tick_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !tick |=> $stable(clk_out));

  // R9: pulse lasts a single cycle
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tick |=> !tick);
endmodule

bind ratediv_top ratediv_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .cnt        (cnt),
  .limit      (limit),
  .tick       (tick),
  .clk_out    (clk_out)
);

// File: tb/sim_ratediv_top.sv
`timescale 1ns/1ps
module sim_ratediv_top;
  localparam int unsigned SLOW = 25;
  localparam int unsigned FAST = SLOW / 5;  // what the default FAST_DIV must give (R5)

  logic clk = 1'b0;
  logic rst_n;
  logic rate_fast;
  logic clk_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  int unsigned m_cnt;
  bit m_tick, m_out, m_s1, m_s2;

  always #10 clk = ~clk;

  ratediv_top #(.CNT_W(32), .SLOW_DIV(SLOW)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate_fast (rate_fast),
    .clk_out   (clk_out)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s clk_out actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    m_cnt = 0; m_tick = 0; m_out = 0; m_s1 = 0; m_s2 = 0;
  endtask

  // one clock: advance the model at the rising edge, compare at the falling edge
  task automatic step(input string req);
    int unsigned lim;
    @(posedge clk);
    if (rst_n) begin
      if (m_s2) begin
        lim = rate_fast ? FAST : SLOW;
        if (m_tick) m_out = !m_out;
        if (m_cnt >= lim) begin m_cnt = 0; m_tick = 1; end
        else begin m_cnt = m_cnt + 1; m_tick = 0; end
      end
      m_s2 = m_s1;
      m_s1 = 1;
    end
    @(negedge clk);
    chk(req, clk_out, m_out);
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    int unsigned edges;
    bit prev;
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd1337);
    rst_n = 1'b0;
    rate_fast = 1'b0;
    model_clear();
    #1;
    chk("R1", clk_out, 1'b0);
    for (int i = 0; i < 4; i++) step("R1");

    // R2: first rise on edge SLOW+4 after release
    rst_n = 1'b1;
    edges = 0;
    prev = 0;
    while (!clk_out && edges < SLOW + 10) begin
      @(posedge clk); edges++;
      if (m_s2) begin
        if (m_tick) m_out = !m_out;
        if (m_cnt >= SLOW) begin m_cnt = 0; m_tick = 1; end
        else begin m_cnt = m_cnt + 1; m_tick = 0; end
      end
      m_s2 = m_s1; m_s1 = 1;
      @(negedge clk);
      prev = clk_out;
    end
    checks++;
    if (edges != SLOW + 4) begin
      fails++;
      $display("FAIL R2 first rise edge actual=%0d expected=%0d", edges, SLOW + 4);
    end
    chk("R2", clk_out, m_out);

    // R3: slow half-periods
    for (int i = 0; i < 3 * (SLOW + 1); i++) step("R3");

    // R4/R5: fast half-periods with default FAST_DIV
    rate_fast = 1'b1;
    for (int i = 0; i < 6 * (FAST + 1); i++) step("R4_R5");

    // R6: go slow, wait for count well above the fast limit, then switch
    rate_fast = 1'b0;
    while (m_cnt < FAST + 10) step("R3");
    rate_fast = 1'b1;
    prev = clk_out;
    step("R6");
    chk("R6", clk_out, prev);
    step("R6");
    chk("R6", clk_out, !prev);
    for (int i = 0; i < 2 * (FAST + 1); i++) step("R6");

    // R7: fast to slow early in a half-period
    while (m_cnt != 2) step("R4");
    rate_fast = 1'b0;
    for (int i = 0; i < 3 * (SLOW + 1); i++) step("R7");

    // R8/R9: random rate segments
    for (int s = 0; s < 250; s++) begin
      int unsigned len;
      rate_fast = $urandom_range(1, 0) == 1;
      len = $urandom_range(40, 1);
      for (int i = 0; i < int'(len); i++) step("R8");
    end

    // R1: asynchronous reset between edges while output is high
    while (!m_out) step("R8");
    #3 rst_n = 1'b0;
    model_clear();
    #1 chk("R1", clk_out, 1'b0);
    for (int i = 0; i < 3; i++) step("R1");
    rst_n = 1'b1;
    for (int i = 0; i < 2 * (SLOW + 4); i++) step("R2");

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule